// File: doc/BRIEF.md
# Matrix Multiply Engine

This block is an accelerator on a simple memory-mapped host port. It computes C = A × B, where A is an N×M matrix and B is an M×L matrix of signed 16-bit elements, and C is an N×L matrix of signed 32-bit sums. The host loads A and B into two private storage regions, one element per word and in row-major order. It then writes a packed control word that carries the three sizes and a start bit.

A sequencer then walks the output rows, the output columns and the inner-product index. It feeds one multiply-accumulate unit and stores every finished sum into the result region. When the whole result is stored it raises a finish flag. The host polls this flag on a pin or through the status word, and then reads C back.

The sequencer states are:
- IDLE: waits for an accepted start.
- LOAD: clears the row and output pointers.
- ROWSET: clears the column.
- CLR: clears the accumulator and the inner index.
- ADDR: issues the A and B addresses.
- READ: the memories return the elements.
- MAC: accumulates the product.
- WRITE: stores one result.
- ROWNEXT: advances the row.
- DONE: sets finish.

The transitions are:
- IDLE→LOAD on an accepted start.
- LOAD→DONE on any zero size, otherwise LOAD→ROWSET.
- ROWSET→CLR, CLR→ADDR, ADDR→READ and READ→MAC.
- MAC→ADDR while inner terms remain, otherwise MAC→WRITE.
- WRITE→CLR while columns remain, otherwise WRITE→ROWNEXT.
- ROWNEXT→ROWSET while rows remain, otherwise ROWNEXT→DONE.
- DONE→IDLE.

Top module: `mm_engine`

## Requirements
- R1: After reset, run_done is 0, hst_rdata is 0 and the sequencer is idle.
- R2: The two top bits of hst_addr select the region: 0 is A, 1 is B, 2 is C and 3 is control/status. The low AW bits are the element index. A and B keep the low 16 bits of each written word as a signed element, in row-major order.
- R3: The control word holds start in bit 0, N in bits 7:1, M in bits 14:8 and L in bits 21:15, all unsigned. A run starts only on a region-3 write with bit 0 set while the sequencer is idle.
- R4: For every r < N and c < L, C word r·L+c equals the sum over i < M of A[r·M+i]·B[i·L+c]. The inputs are signed 16-bit values and the sum is a signed 32-bit value. N·M, M·L and N·L must not exceed 2^AW.
- R5: Sums that leave the 32-bit signed range wrap modulo 2^32.
- R6: Count the cycle of the control write as cycle 1. run_done is first seen high in cycle T = 3·M·L·N + 2·L·N + 2·N + 3.
- R7: An accepted start clears run_done, and run_done stays 0 while the run lasts. A read of region 3 returns run_done in bit 0 and zeros above it.
- R8: If N, M or L is 0, run_done is set with T = 3 and region C is left unchanged.
- R9: Host reads of regions A and B return 0. Host writes to region C leave its contents unchanged.
- R10: A control write with bit 0 clear changes nothing. A control write while a run is in progress is ignored, and that run keeps its sizes and timing.
- R11: Read data for a read issued in one cycle appears on hst_rdata in the next cycle.
- R12: The accumulator restarts from zero for every output element and runs back to back. It does not change outside the clear and accumulate steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_we | input | 1 | Host write strobe |
| hst_re | input | 1 | Host read strobe |
| hst_addr | input | AW+2 | Region (top 2 bits) and element index |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, one cycle after the read |
| run_done | output | 1 | Finish flag |

## Verification
Read data is due one clock after the read strobe, so the bench drives at the falling edge and samples at the next falling edge, after the capturing rising edge. Run length is measured by a free-running edge counter. The bench takes the counter value at the first falling edge after the control write is accepted and compares the value at the first falling edge with run_done high against 3·M·L·N + 2·L·N + 2·N + 3. That first falling edge is also where the bench checks that run_done has dropped. A control write issued in mid-run must leave the elapsed count of the first run unchanged.

// File: rtl/mm_pkg.sv
package mm_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LOAD,
        ST_ROWSET,
        ST_CLR,
        ST_ADDR,
        ST_READ,
        ST_MAC,
        ST_WRITE,
        ST_ROWNEXT,
        ST_DONE
    } mm_state_e;

    localparam logic [1:0] RG_A   = 2'd0;
    localparam logic [1:0] RG_B   = 2'd1;
    localparam logic [1:0] RG_C   = 2'd2;
    localparam logic [1:0] RG_CTL = 2'd3;

endpackage

// File: rtl/mm_ram.sv
module mm_ram #(
    parameter int W  = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/mm_mac.sv
module mm_mac #(
    parameter int IN_W  = 16,
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [IN_W-1:0]  a,
    input  logic [IN_W-1:0]  b,
    output logic [ACC_W-1:0] acc
);
    localparam int PW = 2 * IN_W;

    logic signed [PW-1:0]    prod;
    logic signed [ACC_W-1:0] prod_ext;

    assign prod     = $signed(a) * $signed(b);
    assign prod_ext = ACC_W'(prod);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clr) begin
            acc <= '0;
        end else if (en) begin
            acc <= acc + prod_ext;
        end
    end
endmodule

// File: rtl/mm_seq.sv
module mm_seq
    import mm_pkg::*;
#(
    parameter int DIM_W = 7,
    parameter int AW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [DIM_W-1:0] n_in,
    input  logic [DIM_W-1:0] m_in,
    input  logic [DIM_W-1:0] l_in,
    output mm_state_e        state_o,
    output logic             finish,
    output logic [AW-1:0]    a_raddr,
    output logic [AW-1:0]    b_raddr,
    output logic             c_we,
    output logic [AW-1:0]    c_waddr,
    output logic             mac_clr,
    output logic             mac_en
);
    mm_state_e        state, nxt;
    logic [DIM_W-1:0] n_q, m_q, l_q;
    logic [DIM_W-1:0] row, col, k;
    logic [AW-1:0]    row_a, bptr, cptr;
    logic             any_zero, last_k, last_col, last_row;

    assign any_zero = (n_q == '0) || (m_q == '0) || (l_q == '0);
    assign last_k   = (k   == m_q - 1'b1);
    assign last_col = (col == l_q - 1'b1);
    assign last_row = (row == n_q - 1'b1);

    assign state_o = state;
    assign c_we    = (state == ST_WRITE);
    assign mac_clr = (state == ST_CLR);
    assign mac_en  = (state == ST_MAC);
    assign c_waddr = cptr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    nxt = go ? ST_LOAD : ST_IDLE;
            ST_LOAD:    nxt = any_zero ? ST_DONE : ST_ROWSET;
            ST_ROWSET:  nxt = ST_CLR;
            ST_CLR:     nxt = ST_ADDR;
            ST_ADDR:    nxt = ST_READ;
            ST_READ:    nxt = ST_MAC;
            ST_MAC:     nxt = last_k ? ST_WRITE : ST_ADDR;
            ST_WRITE:   nxt = last_col ? ST_ROWNEXT : ST_CLR;
            ST_ROWNEXT: nxt = last_row ? ST_DONE : ST_ROWSET;
            ST_DONE:    nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // indices, addresses and finish flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q <= '0; m_q <= '0; l_q <= '0;
            row <= '0; col <= '0; k <= '0;
            row_a <= '0; bptr <= '0; cptr <= '0;
            a_raddr <= '0; b_raddr <= '0;
            finish <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (go) begin
                        n_q    <= n_in;
                        m_q    <= m_in;
                        l_q    <= l_in;
                        finish <= 1'b0;
                    end
                end
                ST_LOAD: begin
                    row   <= '0;
                    row_a <= '0;
                    cptr  <= '0;
                end
                ST_ROWSET: col <= '0;
                ST_CLR: begin
                    k    <= '0;
                    bptr <= AW'(col);
                end
                ST_ADDR: begin
                    a_raddr <= row_a + AW'(k);
                    b_raddr <= bptr;
                end
                ST_READ: ;
                ST_MAC: begin
                    k    <= k + 1'b1;
                    bptr <= bptr + AW'(l_q);
                end
                ST_WRITE: begin
                    cptr <= cptr + 1'b1;
                    col  <= col + 1'b1;
                end
                ST_ROWNEXT: begin
                    row   <= row + 1'b1;
                    row_a <= row_a + AW'(m_q);
                end
                ST_DONE: finish <= 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mm_engine.sv
module mm_engine
    import mm_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DIM_W = 7,
    parameter int IN_W  = 16,
    parameter int ACC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hst_we,
    input  logic            hst_re,
    input  logic [AW+1:0]   hst_addr,
    input  logic [ACC_W-1:0] hst_wdata,
    output logic [ACC_W-1:0] hst_rdata,
    output logic            run_done
);
    localparam int NRAM = 2;

    logic [1:0]       rg;
    logic [AW-1:0]    off;
    logic             go;
    mm_state_e        state;
    logic [AW-1:0]    a_raddr, b_raddr, c_waddr;
    logic             c_we, mac_clr, mac_en;
    logic [ACC_W-1:0] acc, c_rdata;
    logic [IN_W-1:0]  ab_rdata [NRAM];
    logic [AW-1:0]    ab_raddr [NRAM];
    logic             rd_c_q, rd_st_q, st_q;

    assign rg  = hst_addr[AW+1:AW];
    assign off = hst_addr[AW-1:0];
    assign go  = hst_we && (rg == RG_CTL) && hst_wdata[0];

    assign ab_raddr[0] = a_raddr;
    assign ab_raddr[1] = b_raddr;

    for (genvar g = 0; g < NRAM; g++) begin : g_in_ram
        mm_ram #(.W(IN_W), .AW(AW)) i_ram (
            .clk   (clk),
            .we    (hst_we && (rg == 2'(g))),
            .waddr (off),
            .wdata (hst_wdata[IN_W-1:0]),
            .raddr (ab_raddr[g]),
            .rdata (ab_rdata[g])
        );
    end

    mm_ram #(.W(ACC_W), .AW(AW)) i_cram (
        .clk   (clk),
        .we    (c_we),
        .waddr (c_waddr),
        .wdata (acc),
        .raddr (off),
        .rdata (c_rdata)
    );

    mm_seq #(.DIM_W(DIM_W), .AW(AW)) i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .n_in    (hst_wdata[DIM_W:1]),
        .m_in    (hst_wdata[2*DIM_W:DIM_W+1]),
        .l_in    (hst_wdata[3*DIM_W:2*DIM_W+1]),
        .state_o (state),
        .finish  (run_done),
        .a_raddr (a_raddr),
        .b_raddr (b_raddr),
        .c_we    (c_we),
        .c_waddr (c_waddr),
        .mac_clr (mac_clr),
        .mac_en  (mac_en)
    );

    mm_mac #(.IN_W(IN_W), .ACC_W(ACC_W)) i_mac (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (mac_clr),
        .en    (mac_en),
        .a     (ab_rdata[0]),
        .b     (ab_rdata[1]),
        .acc   (acc)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_c_q  <= 1'b0;
            rd_st_q <= 1'b0;
            st_q    <= 1'b0;
        end else begin
            rd_c_q  <= hst_re && (rg == RG_C);
            rd_st_q <= hst_re && (rg == RG_CTL);
            st_q    <= run_done;
        end
    end

    assign hst_rdata = rd_c_q  ? c_rdata :
                       rd_st_q ? ACC_W'(st_q) : '0;
endmodule

// File: rtl/mm_checker.sv
module mm_checker
    import mm_pkg::*;
#(
    parameter int AW    = 8,
    parameter int ACC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input mm_state_e        state,
    input logic             finish,
    input logic             go,
    input logic             hst_re,
    input logic [AW+1:0]    hst_addr,
    input logic [ACC_W-1:0] hst_rdata,
    input logic             mac_clr,
    input logic             mac_en,
    input logic [ACC_W-1:0] acc
);
    AST_BUSY_FINISH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> !finish); // R7

    AST_GO_CLEARS_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        (go && state == ST_IDLE) |=> !finish); // R7

    AST_FINISH_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(finish) |-> ($past(state) == ST_DONE)); // R6

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (go && state != ST_IDLE) |=> (state != ST_LOAD)); // R10

    AST_AB_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_re && !hst_addr[AW+1]) |=> (hst_rdata == '0)); // R9

    AST_ACC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mac_clr && !mac_en) |=> $stable(acc)); // R12
endmodule

bind mm_engine mm_checker #(.AW(AW), .ACC_W(ACC_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .finish    (run_done),
    .go        (go),
    .hst_re    (hst_re),
    .hst_addr  (hst_addr),
    .hst_rdata (hst_rdata),
    .mac_clr   (mac_clr),
    .mac_en    (mac_en),
    .acc       (acc)
);

// File: tb/test_mm_engine.sv
`timescale 1ns/1ps
module test_mm_engine;
    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam logic [AW+1:0] BASE_A   = 10'h000;
    localparam logic [AW+1:0] BASE_B   = 10'h100;
    localparam logic [AW+1:0] BASE_C   = 10'h200;
    localparam logic [AW+1:0] BASE_CTL = 10'h300;

    logic        clk = 0, rst_n = 0;
    logic        hst_we = 0, hst_re = 0;
    logic [AW+1:0] hst_addr = '0;
    logic [31:0] hst_wdata = '0;
    logic [31:0] hst_rdata;
    logic        run_done;

    int total = 0, bad = 0, cyc = 0;
    logic signed [15:0] ma [DEPTH];
    logic signed [15:0] mb [DEPTH];
    logic signed [31:0] mc [DEPTH];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mm_engine i_mm_engine (
        .clk(clk), .rst_n(rst_n), .hst_we(hst_we), .hst_re(hst_re),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata),
        .hst_rdata(hst_rdata), .run_done(run_done)
    );

    function automatic int tcalc(int n, int m, int l);
        return 3*m*l*n + 2*l*n + 2*n + 3;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(logic [AW+1:0] a, logic [31:0] d);
        @(negedge clk);
        hst_we = 1; hst_addr = a; hst_wdata = d;
        @(negedge clk);
        hst_we = 0;
    endtask

    task automatic hread(logic [AW+1:0] a, output logic [31:0] d);
        @(negedge clk);
        hst_re = 1; hst_addr = a;
        @(negedge clk);
        hst_re = 0;
        d = hst_rdata;
    endtask

    function automatic logic [31:0] ctl(int n, int m, int l, bit s);
        return (32'(l) << 15) | (32'(m) << 8) | (32'(n) << 1) | 32'(s);
    endfunction

    // kind 0: random, 1: A=i+j B=i-j, 2: all -32768
    task automatic fill(int n, int m, int l, int kind);
        for (int r = 0; r < n; r++)
            for (int c = 0; c < m; c++) begin
                ma[r*m+c] = (kind == 0) ? 16'($urandom) :
                            (kind == 1) ? 16'(r + c) : 16'h8000;
                hwrite(BASE_A + 10'(r*m+c), {16'hABCD, ma[r*m+c]});
            end
        for (int r = 0; r < m; r++)
            for (int c = 0; c < l; c++) begin
                mb[r*l+c] = (kind == 0) ? 16'($urandom) :
                            (kind == 1) ? 16'(r - c) : 16'h8000;
                hwrite(BASE_B + 10'(r*l+c), {16'h1234, mb[r*l+c]});
            end
        for (int r = 0; r < n; r++)
            for (int c = 0; c < l; c++) begin
                logic signed [31:0] s = 0;
                for (int i = 0; i < m; i++)
                    s = s + 32'(ma[r*m+i] * mb[i*l+c]);
                mc[r*l+c] = s;
            end
    endtask

    // issues the control word, returns run length in cycles (R6 convention)
    task automatic run(int n, int m, int l, output int t);
        int c0;
        @(negedge clk);
        hst_we = 1; hst_addr = BASE_CTL; hst_wdata = ctl(n, m, l, 1);
        @(negedge clk);
        hst_we = 0;
        c0 = cyc;
        chk("R7 finish cleared by start", 32'(run_done), 32'd0);
        while (!run_done && cyc - c0 < 100000) @(negedge clk);
        t = cyc - c0 + 1;
    endtask

    task automatic check_c(int n, int l, string req);
        logic [31:0] d;
        for (int i = 0; i < n*l; i++) begin
            hread(BASE_C + 10'(i), d);
            chk(req, d, mc[i]);
        end
    endtask

    task automatic t_reset();
        chk("R1 run_done after reset", 32'(run_done), 32'd0);
        chk("R1 rdata after reset", hst_rdata, 32'd0);
    endtask

    task automatic t_small();
        int t;
        logic [31:0] d;
        fill(2, 2, 1, 0);
        run(2, 2, 1, t);
        chk("R6 cycles 2x2x1", 32'(t), 32'(tcalc(2, 2, 1)));
        check_c(2, 1, "R4/R2/R11 small product");
        hread(BASE_CTL, d);
        chk("R7 status bit", d, 32'd1);
    endtask

    task automatic t_pattern();
        int t;
        fill(4, 5, 3, 1);
        run(4, 5, 3, t);
        chk("R6 cycles 4x5x3", 32'(t), 32'(tcalc(4, 5, 3)));
        check_c(4, 3, "R4/R12 patterned product");
    endtask

    task automatic t_random();
        int t;
        fill(3, 7, 6, 0);
        run(3, 7, 6, t);
        chk("R6 cycles 3x7x6", 32'(t), 32'(tcalc(3, 7, 6)));
        check_c(3, 6, "R4/R3 random product");
    endtask

    task automatic t_minimal();
        int t;
        fill(1, 1, 1, 0);
        run(1, 1, 1, t);
        chk("R6 cycles 1x1x1", 32'(t), 32'd10);
        check_c(1, 1, "R4 single element");
    endtask

    task automatic t_overflow();
        int t;
        logic [31:0] d;
        fill(1, 2, 1, 2);
        run(1, 2, 1, t);
        hread(BASE_C, d);
        chk("R5 wrap to minimum", d, 32'h8000_0000);
    endtask

    task automatic t_zero();
        int t;
        run(0, 2, 2, t);
        chk("R8 zero N cycles", 32'(t), 32'd3);
        check_c(1, 1, "R8 C unchanged after zero N");
        run(1, 0, 1, t);
        chk("R8 zero M cycles", 32'(t), 32'd3);
        check_c(1, 1, "R8 C unchanged after zero M");
    endtask

    task automatic t_access();
        logic [31:0] d;
        hread(BASE_A, d);
        chk("R9 read of A", d, 32'd0);
        hread(BASE_B + 10'd1, d);
        chk("R9 read of B", d, 32'd0);
        hwrite(BASE_C, 32'hDEAD_BEEF);
        check_c(1, 1, "R9 host write to C ignored");
    endtask

    task automatic t_nostart();
        logic [31:0] d;
        hwrite(BASE_CTL, ctl(1, 1, 1, 0));
        repeat (12) @(negedge clk);
        chk("R10 start=0 keeps finish", 32'(run_done), 32'd1);
        check_c(1, 1, "R10 start=0 leaves C");
        hread(BASE_CTL, d);
        chk("R10 status after start=0", d, 32'd1);
    endtask

    task automatic t_busy();
        int c0, t;
        fill(2, 3, 2, 0);
        @(negedge clk);
        hst_we = 1; hst_addr = BASE_CTL; hst_wdata = ctl(2, 3, 2, 1);
        @(negedge clk);
        hst_we = 0;
        c0 = cyc;
        repeat (3) @(negedge clk);
        hwrite(BASE_CTL, ctl(1, 1, 1, 1));
        chk("R7 finish low mid-run", 32'(run_done), 32'd0);
        while (!run_done && cyc - c0 < 100000) @(negedge clk);
        t = cyc - c0 + 1;
        chk("R10 busy start ignored, cycles", 32'(t), 32'(tcalc(2, 3, 2)));
        check_c(2, 2, "R10 busy start ignored, result");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_small();
        t_pattern();
        t_random();
        t_minimal();
        t_overflow();
        t_zero();
        t_access();
        t_nostart();
        t_busy();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule